// File: doc/BRIEF.md
# Indirect PLL Configuration Register Port

This block gives a host bus byte-wide access to a small bank of clock-synthesizer configuration registers through a two-location window. The host first writes an address byte. That byte carries a register index and an arm bit. It then reads or writes the data location, which sits at the next window address. Data writes are accepted only while the port is armed. Software drops the arm bit by rewriting the address byte without it.

The bank holds ten registers:
- the shared reference divider
- a general control byte
- the memory/chip-clock feedback divider
- an extended control byte
- a pixel-clock control byte
- a pixel post-divider byte
- four pixel-clock feedback dividers, one for each selectable pixel clock

The decoded divider values drive an external clock generator model. The PLL itself and the clock muxing sit outside this block.

The port is built around a two-state machine.
- `ST_LOCKED` is the reset state. Data writes are refused in this state.
- `ST_ARMED` accepts data writes.
- Transition `T_ARM`: an address-byte write with the arm bit set moves the port to `ST_ARMED`, from either state.
- Transition `T_DISARM`: an address-byte write with the arm bit clear moves the port to `ST_LOCKED`.
- Transition `T_HOLD`: every other cycle leaves the state unchanged, including data writes and reads.

Top module: `pll_indirect_port`

## Requirements
- R1: After reset, all ten registers are zero, the port is in `ST_LOCKED`, `wr_err_o` is 0 and `bus_rdata` is 0.
- R2: The address byte holds the register index in bits [7:2] and the arm bit in bit 0. A read with `bus_sel`=0 returns the last address byte written.
- R3: A data write (`bus_sel`=1) in `ST_ARMED` stores `bus_wdata` into the register selected by the index. The port stays armed, so several writes in a row are all accepted.
- R4: A data write in `ST_LOCKED` leaves every register unchanged and sets `wr_err_o`. `wr_err_o` then stays 1 until reset.
- R5: A read is registered. `bus_rdata` takes the selected value on the clock edge that samples `bus_rd`. With `bus_sel`=1 that value is the register chosen by the last address byte.
- R6: Register map: index 0 = reference divider, 1 = general control, 2 = memory feedback divider, 3 = extended control, 4 = pixel control, 5 = pixel post-divider, 6..9 = pixel feedback dividers 0..3. Indices 10..63 read as zero, and writes to them change no register.
- R7: Rewriting the address byte with bit 0 clear returns the port to `ST_LOCKED`. Data writes after that are refused as in R4.
- R8: `mem_fb_eff_o` equals the memory feedback divider when extended-control bit 3 is 0, and twice that value (9 bits) when bit 3 is 1. `mem_post_sel_o` equals extended-control bits [2:0].
- R9: `pix_post_sel_o` equals bits [1:0] of the pixel post-divider register. All 8 bits of that register are stored and read back, so software can do a read-modify-write.
- R10: `ref_div_o`, `gen_ctl_o` and `pix_ctl_o` follow their registers. `pix_fb_div_o` packs pixel feedback divider k into bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Window location: 0 = address byte, 1 = data byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ref_div_o | output | 8 | Reference divider |
| gen_ctl_o | output | 8 | General control byte |
| mem_fb_eff_o | output | 9 | Effective memory feedback divider |
| mem_post_sel_o | output | 3 | Memory post-divider select |
| pix_ctl_o | output | 8 | Pixel control byte |
| pix_post_sel_o | output | 2 | Pixel post-divider select |
| pix_fb_div_o | output | 32 | Four packed pixel feedback dividers |
| wr_err_o | output | 1 | Sticky refused-write flag |

## Verification
A wrong arm state shows up at the ports on the cycle after the next data write. If the port wrongly refuses the write, the divider outputs keep their old value and `wr_err_o` rises. If it wrongly accepts the write, a divider changes when it should not. A bad index latch shows up one cycle after a read, as the wrong byte on `bus_rdata`, or as a divider output moving when a different register was addressed. The bench compares every output against a byte-level model after each bus operation, so any such error is reported within one operation.

// File: rtl/pll_port_pkg.sv
package pll_port_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } port_state_e;

    localparam int IDX_REF_DIV  = 0;
    localparam int IDX_GEN_CTL  = 1;
    localparam int IDX_MEM_FB   = 2;
    localparam int IDX_EXT_CTL  = 3;
    localparam int IDX_PIX_CTL  = 4;
    localparam int IDX_PIX_POST = 5;
    localparam int NUM_BASE     = 6;
    localparam int IDX_PIX_FB0  = NUM_BASE;

    localparam int ARM_BIT      = 0;
    localparam int IDX_LSB      = 2;

endpackage

// File: rtl/pll_port_fsm.sv
module pll_port_fsm
    import pll_port_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = DATA_W - IDX_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] addr_byte_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              commit_o,
    output logic              refuse_o,
    output logic              wr_err_o
);

    port_state_e state_q, state_d;
    logic [DATA_W-1:0] addr_q;
    logic              err_q;
    logic              addr_wr;
    logic              data_wr;

    assign addr_wr = bus_wr && !bus_sel;
    assign data_wr = bus_wr &&  bus_sel;

    // next-state logic: T_ARM, T_DISARM, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (addr_wr && bus_wdata[ARM_BIT])  state_d = ST_ARMED;
            ST_ARMED:  if (addr_wr && !bus_wdata[ARM_BIT]) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // output decode per state
    always_comb begin
        commit_o = 1'b0;
        refuse_o = 1'b0;
        unique case (state_q)
            ST_LOCKED: refuse_o = data_wr;
            ST_ARMED:  commit_o = data_wr;
            default: begin
                commit_o = 1'b0;
                refuse_o = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (addr_wr)  addr_q <= bus_wdata;
            if (refuse_o) err_q  <= 1'b1;
        end
    end

    assign addr_byte_o = addr_q;
    assign idx_o       = addr_q[DATA_W-1:IDX_LSB];
    assign wr_err_o    = err_q;

    // R2
    arm_on_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && bus_wdata[ARM_BIT]) |=> (state_q == ST_ARMED));

    // R7
    disarm_on_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !bus_wdata[ARM_BIT]) |=> (state_q == ST_LOCKED));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R4
    refuse_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refuse_o |=> err_q);

    // R3
    commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && refuse_o));

endmodule

// File: rtl/pll_reg_bank.sv
module pll_reg_bank
    import pll_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_PIX = 4,
    localparam int IDX_W  = DATA_W - IDX_LSB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [NUM_BASE*DATA_W-1:0]  base_o,
    output logic [NUM_PIX*DATA_W-1:0]   pix_o
);

    for (genvar k = 0; k < NUM_BASE; k++) begin : g_base
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else if (commit_i && (idx_i == IDX_W'(k))) r_q <= wdata_i;
        end
        assign base_o[k*DATA_W +: DATA_W] = r_q;
    end

    for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else if (commit_i && (idx_i == IDX_W'(IDX_PIX_FB0 + p))) r_q <= wdata_i;
        end
        assign pix_o[p*DATA_W +: DATA_W] = r_q;
    end

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(base_o) && $stable(pix_o)));

    // R6
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_i >= IDX_W'(NUM_BASE + NUM_PIX)) |=> ($stable(base_o) && $stable(pix_o)));

endmodule

// File: rtl/pll_read_mux.sv
module pll_read_mux
    import pll_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_PIX = 4,
    localparam int IDX_W  = DATA_W - IDX_LSB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_i,
    input  logic                        sel_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [DATA_W-1:0]           addr_byte_i,
    input  logic [NUM_BASE*DATA_W-1:0]  base_i,
    input  logic [NUM_PIX*DATA_W-1:0]   pix_i,
    output logic [DATA_W-1:0]           rdata_o
);

    logic [DATA_W-1:0] reg_sel;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        reg_sel = '0;
        for (int k = 0; k < NUM_BASE; k++) begin
            if (idx_i == IDX_W'(k)) reg_sel = base_i[k*DATA_W +: DATA_W];
        end
        for (int p = 0; p < NUM_PIX; p++) begin
            if (idx_i == IDX_W'(IDX_PIX_FB0 + p)) reg_sel = pix_i[p*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= sel_i ? reg_sel : addr_byte_i;
    end

    assign rdata_o = rdata_q;

    // R6
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i && (idx_i >= IDX_W'(NUM_BASE + NUM_PIX))) |=> (rdata_o == '0));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/pll_indirect_port.sv
module pll_indirect_port
    import pll_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_PIX = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [DATA_W-1:0]         ref_div_o,
    output logic [DATA_W-1:0]         gen_ctl_o,
    output logic [DATA_W:0]           mem_fb_eff_o,
    output logic [2:0]                mem_post_sel_o,
    output logic [DATA_W-1:0]         pix_ctl_o,
    output logic [1:0]                pix_post_sel_o,
    output logic [NUM_PIX*DATA_W-1:0] pix_fb_div_o,
    output logic                      wr_err_o
);

    localparam int IDX_W = DATA_W - IDX_LSB;

    logic [DATA_W-1:0]          addr_byte;
    logic [IDX_W-1:0]           idx;
    logic                       commit;
    logic                       refuse;
    logic [NUM_BASE*DATA_W-1:0] base;
    logic [NUM_PIX*DATA_W-1:0]  pix;
    logic [DATA_W-1:0]          mem_fb;
    logic [DATA_W-1:0]          ext_ctl;

    pll_port_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .addr_byte_o (addr_byte),
        .idx_o       (idx),
        .commit_o    (commit),
        .refuse_o    (refuse),
        .wr_err_o    (wr_err_o)
    );

    pll_reg_bank #(.DATA_W(DATA_W), .NUM_PIX(NUM_PIX)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .idx_i    (idx),
        .wdata_i  (bus_wdata),
        .base_o   (base),
        .pix_o    (pix)
    );

    pll_read_mux #(.DATA_W(DATA_W), .NUM_PIX(NUM_PIX)) u_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (bus_rd),
        .sel_i       (bus_sel),
        .idx_i       (idx),
        .addr_byte_i (addr_byte),
        .base_i      (base),
        .pix_i       (pix),
        .rdata_o     (bus_rdata)
    );

    assign mem_fb  = base[IDX_MEM_FB*DATA_W +: DATA_W];
    assign ext_ctl = base[IDX_EXT_CTL*DATA_W +: DATA_W];

    assign ref_div_o      = base[IDX_REF_DIV*DATA_W +: DATA_W];
    assign gen_ctl_o      = base[IDX_GEN_CTL*DATA_W +: DATA_W];
    assign pix_ctl_o      = base[IDX_PIX_CTL*DATA_W +: DATA_W];
    assign pix_post_sel_o = base[IDX_PIX_POST*DATA_W +: 2];
    assign mem_post_sel_o = ext_ctl[2:0];
    assign mem_fb_eff_o   = ext_ctl[3] ? {mem_fb, 1'b0} : {1'b0, mem_fb};
    assign pix_fb_div_o   = pix;

    // R8
    fb_eff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ctl[3] |-> (mem_fb_eff_o[DATA_W] == 1'b0));

    // R8
    fb_eff_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ctl[3] |-> (mem_fb_eff_o[0] == 1'b0));

endmodule

// File: tb/pll_indirect_port_tb.sv
module pll_indirect_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, ref_div_o, gen_ctl_o, pix_ctl_o;
    logic [8:0]  mem_fb_eff_o;
    logic [2:0]  mem_post_sel_o;
    logic [1:0]  pix_post_sel_o;
    logic [31:0] pix_fb_div_o;
    logic        wr_err_o;

    int checks = 0, errors = 0;
    logic [7:0] mreg [0:9];
    logic [7:0] maddr = '0;
    logic       marm = 1'b0, merr = 1'b0;

    always #2.5 clk = ~clk;

    pll_indirect_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_div_o(ref_div_o),
        .gen_ctl_o(gen_ctl_o), .mem_fb_eff_o(mem_fb_eff_o), .mem_post_sel_o(mem_post_sel_o),
        .pix_ctl_o(pix_ctl_o), .pix_post_sel_o(pix_post_sel_o), .pix_fb_div_o(pix_fb_div_o),
        .wr_err_o(wr_err_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(logic [7:0] a);
        int i = int'(a[7:2]);
        return (i < 10) ? mreg[i] : 8'h00;
    endfunction

    function automatic logic [8:0] m_fb_eff();
        return mreg[3][3] ? {mreg[2], 1'b0} : {1'b0, mreg[2]};
    endfunction

    task automatic check_outs();
        chk("R10 ref_div", 32'(ref_div_o), 32'(mreg[0]));
        chk("R10 gen_ctl", 32'(gen_ctl_o), 32'(mreg[1]));
        chk("R8 mem_fb_eff", 32'(mem_fb_eff_o), 32'(m_fb_eff()));
        chk("R8 mem_post_sel", 32'(mem_post_sel_o), 32'(mreg[3][2:0]));
        chk("R10 pix_ctl", 32'(pix_ctl_o), 32'(mreg[4]));
        chk("R9 pix_post_sel", 32'(pix_post_sel_o), 32'(mreg[5][1:0]));
        chk("R10 pix_fb_div", pix_fb_div_o, {mreg[9], mreg[8], mreg[7], mreg[6]});
        chk("R4 wr_err", 32'(wr_err_o), 32'(merr));
    endtask

    task automatic bus_op(logic sel, logic wr, logic rd, logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic addr_wr(int idx, logic arm);
        logic [7:0] b = {6'(idx), 1'b0, arm};
        bus_op(1'b0, 1'b1, 1'b0, b);
        maddr = b; marm = arm;
    endtask

    task automatic data_wr(logic [7:0] d);
        bus_op(1'b1, 1'b1, 1'b0, d);
        if (marm) begin
            if (int'(maddr[7:2]) < 10) mreg[int'(maddr[7:2])] = d;
        end else merr = 1'b1;
    endtask

    task automatic data_rd(string req);
        bus_op(1'b1, 1'b0, 1'b1, 8'h00);
        chk(req, 32'(bus_rdata), 32'(m_read(maddr)));
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++) mreg[i] = 8'h00;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", 32'(bus_rdata), 32'h0);
        check_outs();
        data_wr(8'h55); // R1 locked after reset -> refused, R4
        check_outs();
        // R2 address readback
        addr_wr(3, 1'b1);
        bus_op(1'b0, 1'b0, 1'b1, 8'h00);
        chk("R2 addr readback", 32'(bus_rdata), 32'h0D);
        // R8 doubling and post select
        data_wr(8'h0D); addr_wr(2, 1'b1); data_wr(8'hC8); check_outs();
        addr_wr(3, 1'b1); data_wr(8'h05); check_outs();
        // R3 multiple writes while armed
        addr_wr(5, 1'b1); data_wr(8'hA6); data_wr(8'hF1); check_outs();
        data_rd("R9 post readback");
        // R7 disarm then refuse
        addr_wr(6, 1'b0); data_wr(8'h77); check_outs();
        data_rd("R7 locked write ignored");
        // R6 unmapped
        addr_wr(10, 1'b1); data_wr(8'hEE); check_outs(); data_rd("R6 unmapped read");
        addr_wr(63, 1'b1); data_wr(8'h99); data_rd("R6 unmapped 63");
        // R10 each pixel fb divider
        for (int p = 0; p < 4; p++) begin
            addr_wr(6 + p, 1'b1); data_wr(8'(8'h80 + p * 17)); data_rd("R5 pix fb read");
        end
        check_outs();
        // random phase
        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom_range(0, 3));
            case (op)
                0: addr_wr(int'($urandom_range(0, 15)), 1'($urandom_range(0, 3) != 0));
                1: data_wr(8'($urandom));
                2: data_rd("R5 random read");
                default: begin
                    bus_op(1'b0, 1'b0, 1'b1, 8'h00);
                    chk("R2 random addr read", 32'(bus_rdata), 32'(maddr));
                end
            endcase
            check_outs();
        end
        // R4 sticky until reset, R1 after re-reset
        @(negedge clk); rst_n = 1'b0;
        for (int i = 0; i < 10; i++) mreg[i] = 8'h00;
        maddr = '0; marm = 1'b0; merr = 1'b0;
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R1 rdata after reset", 32'(bus_rdata), 32'h0);
        check_outs();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule